// File: doc/BRIEF.md
# UART Framing Transceiver

This block is the serial engine of an asynchronous serial port. On the transmit side it takes a byte through a valid/ready handshake, wraps it in a start bit, the data bits (LSB first), an optional parity bit and one or two stop bits, and shifts it out on `txd`. On the receive side it watches `rxd`, qualifies a start bit at its centre, samples every following bit at mid-bit, and hands the character to a downstream buffer through a valid/ready handshake. Each received character carries error flags for parity, framing and overrun.

Both directions run from a 16x oversampling tick. The tick comes from a 16-bit divisor that holds the divide value minus one, so one bit lasts 16 × (div + 1) clock cycles. The rate range is therefore clock/(16 × 65536) up to clock/16 in whole steps, with no fractional division. A configuration byte sets the frame shape, and a three-bit control input gates the two directions and returns both engines to idle.

Top module: `uart_frame_engine`

## Requirements
- R1: One bit lasts 16 × (div + 1) clock cycles on both `txd` and `rxd`. Data bits travel LSB first, and the receiver samples each bit near its centre.
- R2: `cfg[0]` sets the character length: 1 gives 8 data bits and 0 gives 7. In 7-bit mode a received byte has bit 7 cleared, and bit 7 of a transmitted byte is not sent.
- R3: With `cfg[1]` set, the transmitter sends two stop bits, so the frame is one bit longer. The receiver checks only the first stop bit.
- R4: `cfg[2]` inserts a parity bit after the data bits. `cfg[4]`=1 makes the parity odd and `cfg[4]`=0 makes it even, counted over data plus parity.
- R5: When parity is enabled and the received parity bit does not match, `status[0]` is 1 while that character is presented.
- R6: A low level sampled in the first stop bit sets `status[1]` for that character.
- R7: A character that completes while `rx_valid` is high and `rx_ready` is low is dropped. `status[2]` is then set on the next character delivered.
- R8: A low pulse on `rxd` that has ended by the middle of the start bit does not start a character.
- R9: `status[6]` is 1 only when no frame is being shifted out and `tx_valid` is low. The `txd` line idles high.
- R10: `ctrl[0]` enables reception of new characters and `ctrl[1]` enables acceptance of transmit bytes. When `ctrl[1]` is low, `tx_ready` is low and nothing is sent.
- R11: `ctrl[2]` (soft reset) aborts any frame in progress in both directions, returns `txd` high and clears `rx_valid` and the pending overrun.
- R12: `rx_data` and `status[2:0]` hold steady while `rx_valid` is high and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 3 | bit0 receive enable, bit1 transmit enable, bit2 soft reset |
| cfg | input | 8 | bit0 8-bit chars, bit1 two stop bits, bit2 parity on, bit4 odd parity |
| div | input | 16 | Baud divisor minus one |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter accepts the byte |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Downstream takes the character |
| status | output | 8 | bit0 parity err, bit1 framing err, bit2 overrun, bit6 transmitter empty |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The hardest case to reach is overrun, because it needs a full frame to finish while an earlier character is still unclaimed. Its flag only shows up one character later. The bench holds `rx_ready` low across two back-to-back frames and checks at the ports that the first character stays in place. It then releases the handshake and sends a third frame, which must arrive with the overrun bit set, while the dropped middle frame never appears. Soft reset is driven in the middle of a frame with the line still low, which shows that the engine does not treat the held level as a new start edge.

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       ctrl,
  input  logic [7:0]       cfg,
  input  logic [DIV_W-1:0] div,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       status,
  input  logic             rxd,
  output logic             txd
);
  localparam int FW = 12;

  logic srst;
  assign srst = ctrl[2];

  // 16x prescaler
  logic [DIV_W-1:0] pcnt;
  logic tick;
  assign tick = (pcnt >= div);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else if (srst || tick) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;

  logic [3:0] dlen;
  assign dlen = cfg[0] ? 4'd8 : 4'd7;

  // receiver
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rstate_t;
  rstate_t rst_q;
  logic [2:0] rsync;
  logic rs, rprev;
  logic [3:0] rscnt, rbits;
  logic [7:0] rsh;
  logic rpar, ovr_pend;
  logic [2:0] rx_err;
  logic [7:0] rword;
  assign rs    = rsync[1];
  assign rprev = rsync[2];
  assign rword = cfg[0] ? rsh : {1'b0, rsh[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync <= 3'b111; rst_q <= R_IDLE; rscnt <= '0; rbits <= '0;
      rsh <= '0; rpar <= 1'b0; ovr_pend <= 1'b0; rx_err <= '0;
      rx_data <= '0; rx_valid <= 1'b0;
    end else begin
      rsync <= {rsync[1:0], rxd};
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (srst) begin
        rst_q <= R_IDLE; rx_valid <= 1'b0; ovr_pend <= 1'b0;
      end else begin
        case (rst_q)
          R_IDLE:
            if (ctrl[0] && rprev && !rs) begin rst_q <= R_START; rscnt <= '0; end
          R_START:
            if (tick) begin
              if (rscnt == 4'd7) begin
                rscnt <= '0; rbits <= '0; rpar <= 1'b0;
                rst_q <= rs ? R_IDLE : R_DATA;
              end else rscnt <= rscnt + 1'b1;
            end
          default:
            if (tick) begin
              if (rscnt == 4'd15) begin
                rscnt <= '0;
                if (rst_q == R_DATA) begin
                  rsh   <= {rs, rsh[7:1]};
                  rpar  <= rpar ^ rs;
                  rbits <= rbits + 1'b1;
                  if (rbits == dlen - 4'd1) rst_q <= cfg[2] ? R_PAR : R_STOP;
                end else if (rst_q == R_PAR) begin
                  rpar  <= rpar ^ rs;
                  rst_q <= R_STOP;
                end else begin
                  rst_q <= R_IDLE;
                  if (rx_valid && !rx_ready) ovr_pend <= 1'b1;
                  else begin
                    rx_valid <= 1'b1;
                    rx_data  <= rword;
                    rx_err   <= {ovr_pend, !rs, cfg[2] && (rpar != cfg[4])};
                    ovr_pend <= 1'b0;
                  end
                end
              end else rscnt <= rscnt + 1'b1;
            end
        endcase
      end
    end
  end

  // transmitter
  logic [FW-1:0] tsh, frame;
  logic [3:0] tleft, tscnt, flen;
  logic tbusy, tpar;
  logic [7:0] dm;
  assign dm   = cfg[0] ? tx_data : {1'b0, tx_data[6:0]};
  assign tpar = ^dm ^ cfg[4];
  assign flen = 4'd9 + {3'b0, cfg[0]} + {3'b0, cfg[2]} + {3'b0, cfg[1]};

  always_comb begin
    frame      = '1;
    frame[0]   = 1'b0;
    frame[8:1] = dm;
    if (!cfg[0]) frame[8] = cfg[2] ? tpar : 1'b1;
    else if (cfg[2]) frame[9] = tpar;
  end

  assign tx_ready = !tbusy && ctrl[1] && !srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh <= '1; tbusy <= 1'b0; tleft <= '0; tscnt <= '0;
    end else if (srst) begin
      tsh <= '1; tbusy <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      tsh <= frame; tbusy <= 1'b1; tleft <= flen; tscnt <= '0;
    end else if (tbusy && tick) begin
      if (tscnt == 4'd15) begin
        tscnt <= '0;
        tsh   <= {1'b1, tsh[FW-1:1]};
        tleft <= tleft - 1'b1;
        if (tleft == 4'd1) tbusy <= 1'b0;
      end else tscnt <= tscnt + 1'b1;
    end
  end

  assign txd    = tsh[0];
  assign status = {1'b0, !tbusy && !tx_valid, 3'b000, rx_err};
endmodule

module uart_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ctrl,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] status,
  input logic       txd
);
  p_hold_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !ctrl[2]) |=> (rx_valid && $stable(rx_data) && $stable(status[2:0])));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !status[6]);

  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> txd);

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[2] |=> (txd && !rx_valid));

  p_tx_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[1] && !ctrl[2] && txd && !tx_ready && status[6]) |=> txd);
endmodule

bind uart_frame_engine uart_frame_engine_chk u_chk (.*);

// File: tb/uart_frame_engine_tb.sv
`timescale 1ns/1ps
module uart_frame_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ctrl = 3'b011;
  logic [7:0] cfg = 8'h01;
  logic [15:0] div = 16'd1;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b1, rxd = 1'b1;
  logic tx_ready, rx_valid, txd;
  logic [7:0] rx_data, status;

  int errors = 0, checks = 0, rx_seen = 0;
  logic [10:0] rx_q[$];
  string rx_tag[$];
  logic [15:0] tx_q[$];
  string tx_tag[$];

  always #4 clk = ~clk;

  uart_frame_engine u_dut (.clk, .rst_n, .ctrl, .cfg, .div, .tx_data, .tx_valid, .tx_ready,
    .rx_data, .rx_valid, .rx_ready, .status, .rxd, .txd);

  function automatic int bitclk();
    return 16 * (int'(div) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * bitclk()) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                         input bit push, input logic [2:0] flags, input string tag);
    logic [7:0] dm;
    int dl;
    dl = cfg[0] ? 8 : 7;
    dm = cfg[0] ? d : {1'b0, d[6:0]};
    if (push) begin rx_q.push_back({flags, dm}); rx_tag.push_back(tag); end
    @(negedge clk);
    rxd = 1'b0; wait_bits(1);
    for (int i = 0; i < dl; i++) begin rxd = dm[i]; wait_bits(1); end
    if (cfg[2]) begin rxd = ^dm ^ cfg[4] ^ bad_par; wait_bits(1); end
    rxd = !bad_stop; wait_bits(1);
    if (cfg[1]) begin rxd = 1'b1; wait_bits(1); end
    rxd = 1'b1; wait_bits(2);
  endtask

  task automatic send_tx(input logic [7:0] d, input string tag, output int dur);
    tx_q.push_back({cfg, d}); tx_tag.push_back(tag);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check(status[6] == 1'b0, "R9", "status bit6 while shifting", status[6], 0);
    dur = 1;
    while (!status[6]) begin @(negedge clk); dur++; end
    wait_bits(1);
  endtask

  task automatic soft_reset();
    @(negedge clk); ctrl[2] = 1'b1;
    @(negedge clk); ctrl[2] = 1'b0;
  endtask

  // receive monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      rx_seen++;
      if (rx_q.size() == 0) check(0, "R12", "unexpected rx char", rx_data, 0);
      else begin
        logic [10:0] e;
        string t;
        e = rx_q.pop_front(); t = rx_tag.pop_front();
        check(rx_data == e[7:0], t, "rx data", rx_data, e[7:0]);
        check(status[2:0] == e[10:8], t, "rx flags", status[2:0], e[10:8]);
      end
    end
  end

  // transmit monitor
  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        if (tx_q.size() == 0) check(0, "R10", "unexpected tx frame", 0, 1);
        else begin
          logic [15:0] it;
          logic [7:0] c, dm, got;
          string t;
          int dl;
          it = tx_q.pop_front(); t = tx_tag.pop_front();
          c = it[15:8]; dl = c[0] ? 8 : 7;
          dm = c[0] ? it[7:0] : {1'b0, it[6:0]};
          got = '0;
          repeat (bitclk() / 2) @(negedge clk);
          check(txd == 1'b0, t, "tx start bit", txd, 0);
          for (int i = 0; i < dl; i++) begin wait_bits(1); got[i] = txd; end
          check(got == dm, t, "tx data LSB first", got, dm);
          if (c[2]) begin
            wait_bits(1);
            check(txd == (^dm ^ c[4]), "R4", "tx parity bit", txd, ^dm ^ c[4]);
          end
          wait_bits(1);
          check(txd == 1'b1, t, "tx stop bit", txd, 1);
        end
      end
      prev = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int dur, seen0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R9", "reset txd", txd, 1);
    check(rx_valid == 1'b0, "R12", "reset rx_valid", rx_valid, 0);
    check(status[6] == 1'b1, "R9", "reset tx empty", status[6], 1);

    // receive, 8N1, div=1
    send_rx(8'hA5, 0, 0, 1, 3'b000, "R1");
    send_rx(8'h3C, 0, 0, 1, 3'b000, "R1");
    cfg = 8'h00; send_rx(8'hD5, 0, 0, 1, 3'b000, "R2");
    cfg = 8'h05; send_rx(8'h37, 0, 0, 1, 3'b000, "R4");
    send_rx(8'h37, 1, 0, 1, 3'b001, "R5");
    cfg = 8'h15; send_rx(8'h37, 0, 0, 1, 3'b000, "R4");
    send_rx(8'hC4, 1, 0, 1, 3'b001, "R5");
    cfg = 8'h01; send_rx(8'h66, 0, 1, 1, 3'b010, "R6");
    cfg = 8'h03; send_rx(8'h81, 0, 0, 1, 3'b000, "R3");
    div = 16'd3; cfg = 8'h01; soft_reset();
    send_rx(8'h5A, 0, 0, 1, 3'b000, "R1");
    div = 16'd0; soft_reset();
    send_rx(8'hE1, 0, 0, 1, 3'b000, "R1");
    div = 16'd1; soft_reset();

    // start glitch
    seen0 = rx_seen;
    @(negedge clk); rxd = 1'b0;
    repeat (3 * 2) @(negedge clk);
    rxd = 1'b1; wait_bits(12);
    check(rx_seen == seen0, "R8", "glitch produced char", rx_seen, seen0);

    // receive disabled
    ctrl[0] = 1'b0;
    send_rx(8'h42, 0, 0, 0, 3'b000, "R10");
    check(rx_seen == seen0, "R10", "char while rx disabled", rx_seen, seen0);
    ctrl[0] = 1'b1;

    // overrun
    rx_ready = 1'b0;
    send_rx(8'h11, 0, 0, 1, 3'b000, "R7");
    send_rx(8'h22, 0, 0, 0, 3'b000, "R7");
    check(rx_valid == 1'b1, "R12", "rx_valid held", rx_valid, 1);
    check(rx_data == 8'h11, "R12", "rx_data held", rx_data, 8'h11);
    @(negedge clk); rx_ready = 1'b1;
    send_rx(8'h33, 0, 0, 1, 3'b100, "R7");

    // soft reset mid-frame with line low
    seen0 = rx_seen;
    @(negedge clk); rxd = 1'b0;
    wait_bits(4);
    soft_reset();
    wait_bits(3);
    rxd = 1'b1; wait_bits(3);
    check(rx_seen == seen0, "R11", "char after soft reset", rx_seen, seen0);
    send_rx(8'h77, 0, 0, 1, 3'b000, "R11");

    // transmit
    cfg = 8'h01; send_tx(8'h96, "R1", dur);
    check(dur >= 10 * bitclk() - bitclk() / 4 && dur <= 10 * bitclk() + bitclk() / 4,
          "R1", "8N1 frame length", dur, 10 * bitclk());
    cfg = 8'h03; send_tx(8'h5B, "R3", dur);
    check(dur >= 11 * bitclk() - bitclk() / 4 && dur <= 11 * bitclk() + bitclk() / 4,
          "R3", "8N2 frame length", dur, 11 * bitclk());
    cfg = 8'h05; send_tx(8'h37, "R4", dur);
    cfg = 8'h15; send_tx(8'h37, "R4", dur);
    cfg = 8'h00; send_tx(8'hFF, "R2", dur);
    check(dur >= 9 * bitclk() - bitclk() / 4 && dur <= 9 * bitclk() + bitclk() / 4,
          "R2", "7N1 frame length", dur, 9 * bitclk());

    // transmit disabled with a byte pending
    cfg = 8'h01; ctrl[1] = 1'b0;
    @(negedge clk); tx_data = 8'hA0; tx_valid = 1'b1;
    wait_bits(3);
    check(tx_ready == 1'b0, "R10", "tx_ready while disabled", tx_ready, 0);
    check(txd == 1'b1, "R10", "txd while disabled", txd, 1);
    check(status[6] == 1'b0, "R9", "tx empty with byte pending", status[6], 0);
    @(negedge clk); tx_valid = 1'b0; ctrl[1] = 1'b1;
    @(negedge clk);
    check(status[6] == 1'b1, "R9", "tx empty when idle", status[6], 1);
    send_tx(8'hA0, "R10", dur);
    wait_bits(2);
    check(tx_q.size() == 0 && rx_q.size() == 0, "R12", "scoreboard drained",
          tx_q.size() + rx_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule